// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block sits between a request queue and the command pins of an SDRAM device whose rows are already open. It takes one READ, WRITE or PRECHARGE request per cycle over a valid/ready handshake. It places each request on a registered command bus (opcode, bank, column, auto-precharge flag) and drives the data-mask pin alongside it. Whenever it has nothing to place, it drives NOP.

Two timing hazards shape the schedule. First, a WRITE that cuts into a read burst that is still returning data needs the mask pin raised ahead of time. The mask acts on output data two cycles late, so the scheduler raises it over a run of NOP cycles. It then drops the mask in the write cycle, because a write would otherwise be masked. Second, a PRECHARGE that ends a read burst early is held back until the last wanted word of that burst is safe. Once a bank is precharged, the block keeps every later command to that bank off the bus for the row precharge time.

CAS latency (2 or 3), burst length, row precharge time and an extra turnaround cycle are runtime configuration inputs.

Top module: `sdram_rw_sched`

## Requirements
- R1: While reset is held, `cmd` is NOP (2'd0), `dqm` is low and `req_ready` is high.
- R2: An accepted request shows up on `cmd`/`cmd_bank`/`cmd_col`/`cmd_ap` in the cycle that follows the accepting edge. The opcode values are READ=2'd1, WRITE=2'd2 and PRECHARGE=2'd3. A request with opcode 2'd0 is accepted and produces no command.
- R3: READ requests to any bank are accepted on consecutive cycles and issued on consecutive cycles.
- R4: With `turn_nop` low, a WRITE that follows a READ whose data window is still open is issued after exactly two NOP cycles. `dqm` is high in both of those cycles.
- R5: `dqm` is low in every cycle that carries a WRITE.
- R6: With `turn_nop` high, the lead before such a WRITE is three cycles. `dqm` is high in all three cycles.
- R7: A WRITE with no read data outstanding is issued in the next cycle and raises no `dqm`.
- R8: A PRECHARGE to the bank of the most recent READ is issued no earlier than `req_len` cycles after that READ. At that point it is CL-1 cycles before the last wanted word at READ+CL+`req_len`-1, so the gap is the same for CL 2 and CL 3.
- R9: A PRECHARGE to a different bank from the most recent READ is not delayed by that READ.
- R10: A PRECHARGE to a bank whose latest READ carried auto-precharge is accepted and dropped, and no command is issued for it.
- R11: After a PRECHARGE to a bank, no command to that bank is issued until `trp_cycles` cycles have passed. Other banks are not held.
- R12: `dqm` is high only in NOP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| turn_nop | input | 1 | Add one idle data cycle before an interrupting write |
| burst_len | input | LEN_W | Burst length in words |
| trp_cycles | input | TRP_W | Row precharge time in cycles (at least 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge |
| req_op | input | 2 | Request opcode |
| req_bank | input | BANK_W | Request bank |
| req_col | input | COL_W | Request column |
| req_len | input | LEN_W | Words wanted from a READ (1..burst_len) |
| req_ap | input | 1 | READ with auto-precharge |
| cmd | output | 2 | Issued command opcode |
| cmd_bank | output | BANK_W | Issued bank |
| cmd_col | output | COL_W | Issued column |
| cmd_ap | output | 1 | Issued auto-precharge flag |
| dqm | output | 1 | Data mask pin |

## Verification
The assertions check four rules on every cycle, whatever the traffic:
- the mask is low on write cycles;
- the mask is high only on NOP cycles;
- a write landing in an open read window has the mask high in both prior cycles;
- no command reaches a bank before its precharge time has elapsed, measured by a counter kept separately from the scheduler's own.

Other behaviour can only be shown by the bench scenarios:
- the exact number of inserted NOPs;
- the precharge gap being independent of CAS latency;
- the silent dropping of a precharge after an auto-precharged read;
- the absence of any delay for unrelated banks.

// File: rtl/sdram_rw_sched.sv
module sdram_rw_sched #(
  parameter int BANKS = 4,
  parameter int COL_W = 8,
  parameter int LEN_W = 4,
  parameter int TRP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cas3,
  input  logic                     turn_nop,
  input  logic [LEN_W-1:0]         burst_len,
  input  logic [TRP_W-1:0]         trp_cycles,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [COL_W-1:0]         req_col,
  input  logic [LEN_W-1:0]         req_len,
  input  logic                     req_ap,
  output logic [1:0]               cmd,
  output logic [$clog2(BANKS)-1:0] cmd_bank,
  output logic [COL_W-1:0]         cmd_col,
  output logic                     cmd_ap,
  output logic                     dqm
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int LIVE_W = LEN_W + 2;
  localparam int AGE_W  = TRP_W + 1;
  localparam logic [1:0] OP_NOP = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_PRE = 2'd3;

  logic [LIVE_W-1:0] live_q, live_dec, cl;
  logic [LEN_W-1:0]  prew_q;
  logic [BANK_W-1:0] rdb_q;
  logic [BANKS-1:0]  apf_q;
  logic [TRP_W-1:0]  trp_q [BANKS];
  logic [1:0]        drun_q, need;
  logic              bank_free, wr_go, pre_drop, pre_go, go, fire, raise;
  logic [1:0]        issue;

  assign cl        = cas3 ? LIVE_W'(3) : LIVE_W'(2);
  assign live_dec  = (live_q == '0) ? '0 : live_q - 1'b1;
  assign bank_free = trp_q[req_bank] <= TRP_W'(1);
  assign need      = (live_q != '0) ? (turn_nop ? 2'd3 : 2'd2) : 2'd0;
  assign wr_go     = bank_free && (drun_q >= need);
  assign pre_drop  = apf_q[req_bank];
  assign pre_go    = bank_free && ((req_bank != rdb_q) || (prew_q <= LEN_W'(1)));

  always_comb begin
    case (req_op)
      OP_RD:   go = bank_free;
      OP_WR:   go = wr_go;
      OP_PRE:  go = pre_drop || pre_go;
      default: go = 1'b1;
    endcase
  end

  assign req_ready = go;
  assign fire      = req_valid && go;
  assign raise     = req_valid && (req_op == OP_WR) && !wr_go && (need != 2'd0);
  assign issue     = (!fire || (req_op == OP_PRE && pre_drop)) ? OP_NOP : req_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= OP_NOP;
      cmd_bank <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      dqm      <= 1'b0;
      drun_q   <= '0;
      live_q   <= '0;
      prew_q   <= '0;
      rdb_q    <= '0;
      apf_q    <= '0;
      for (int b = 0; b < BANKS; b++) trp_q[b] <= '0;
    end else begin
      cmd      <= issue;
      cmd_bank <= req_bank;
      cmd_col  <= req_col;
      cmd_ap   <= req_ap && (issue == OP_RD);
      dqm      <= raise;
      drun_q   <= raise ? ((drun_q == 2'd3) ? 2'd3 : drun_q + 2'd1) : 2'd0;

      if (issue == OP_RD)
        live_q <= cl + LIVE_W'(burst_len);
      else if (issue == OP_PRE && req_bank == rdb_q)
        live_q <= (live_dec > cl) ? cl : live_dec;
      else
        live_q <= live_dec;

      if (issue == OP_RD) begin
        prew_q <= req_len;
        rdb_q  <= req_bank;
      end else if (prew_q != '0) begin
        prew_q <= prew_q - 1'b1;
      end

      if (issue == OP_RD) apf_q[req_bank] <= req_ap;
      else if (issue == OP_WR) apf_q[req_bank] <= 1'b0;

      for (int b = 0; b < BANKS; b++) begin
        if (issue == OP_PRE && req_bank == BANK_W'(b)) trp_q[b] <= trp_cycles;
        else if (trp_q[b] != '0) trp_q[b] <= trp_q[b] - 1'b1;
      end
    end
  end

  // Independent age counters for the precharge-time check
  logic [AGE_W-1:0] age_q [BANKS];
  logic [BANKS-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      for (int b = 0; b < BANKS; b++) age_q[b] <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (cmd == OP_PRE && cmd_bank == BANK_W'(b)) begin
          age_q[b]  <= AGE_W'(1);
          seen_q[b] <= 1'b1;
        end else if (age_q[b] != {AGE_W{1'b1}}) begin
          age_q[b] <= age_q[b] + 1'b1;
        end
      end
    end
  end

  AST_WR_DQM_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cmd == OP_WR) |-> !dqm); // R5
  AST_DQM_ON_NOP: assert property (@(posedge clk) disable iff (!rst_n) dqm |-> (cmd == OP_NOP)); // R12
  AST_WR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == OP_WR && $past(live_q) != '0) |-> ($past(dqm) && $past(dqm, 2))); // R4
  AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != OP_NOP && seen_q[cmd_bank]) |-> (age_q[cmd_bank] >= AGE_W'(trp_cycles))); // R11
endmodule

// File: tb/tb_sdram_rw_sched.sv
module tb_sdram_rw_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [3:0] rid;
    logic       cl3;
    logic       tn;
    logic [1:0] op1;
    logic [1:0] b1;
    logic [3:0] len;
    logic [1:0] op2;
    logic [1:0] b2;
    logic [3:0] gap;
    logic [1:0] dq;
  } vec_t;

  // rid, cl3, tn, op1, b1, len, op2, b2, gap, dqm-count
  localparam vec_t VEC [NV] = '{
    '{4'd4,  1'b0, 1'b0, 2'd1, 2'd0, 4'd4, 2'd2, 2'd0, 4'd3, 2'd2},  // R4 CL2
    '{4'd4,  1'b1, 1'b0, 2'd1, 2'd1, 4'd4, 2'd2, 2'd1, 4'd3, 2'd2},  // R4 CL3
    '{4'd6,  1'b0, 1'b1, 2'd1, 2'd0, 4'd4, 2'd2, 2'd2, 4'd4, 2'd3},  // R6
    '{4'd6,  1'b1, 1'b1, 2'd1, 2'd3, 4'd4, 2'd2, 2'd3, 4'd4, 2'd3},  // R6
    '{4'd8,  1'b0, 1'b0, 2'd1, 2'd0, 4'd2, 2'd3, 2'd0, 4'd2, 2'd0},  // R8 CL2
    '{4'd8,  1'b1, 1'b0, 2'd1, 2'd0, 4'd2, 2'd3, 2'd0, 4'd2, 2'd0},  // R8 CL3
    '{4'd8,  1'b1, 1'b0, 2'd1, 2'd1, 4'd4, 2'd3, 2'd1, 4'd4, 2'd0},  // R8
    '{4'd8,  1'b0, 1'b0, 2'd1, 2'd2, 4'd1, 2'd3, 2'd2, 4'd1, 2'd0},  // R8
    '{4'd9,  1'b0, 1'b0, 2'd1, 2'd0, 4'd3, 2'd3, 2'd1, 4'd1, 2'd0},  // R9
    '{4'd3,  1'b1, 1'b0, 2'd1, 2'd0, 4'd4, 2'd1, 2'd3, 4'd1, 2'd0},  // R3
    '{4'd7,  1'b0, 1'b0, 2'd2, 2'd0, 4'd4, 2'd2, 2'd1, 4'd1, 2'd0},  // R7
    '{4'd11, 1'b0, 1'b0, 2'd3, 2'd2, 4'd4, 2'd1, 2'd2, 4'd3, 2'd0},  // R11 same bank
    '{4'd11, 1'b0, 1'b0, 2'd3, 2'd2, 4'd4, 2'd1, 2'd3, 4'd1, 2'd0}   // R11 other bank
  };

  logic clk = 0, rst_n = 0, cas3 = 0, turn_nop = 0;
  logic [3:0] burst_len = 4'd4, trp_cycles = 4'd3;
  logic req_valid = 0, req_ap = 0, req_ready;
  logic [1:0] req_op = 0, req_bank = 0;
  logic [7:0] req_col = 0;
  logic [3:0] req_len = 4'd4;
  logic [1:0] cmd, cmd_bank;
  logic [7:0] cmd_col;
  logic cmd_ap, dqm;

  sdram_rw_sched dut (
    .clk(clk), .rst_n(rst_n), .cas3(cas3), .turn_nop(turn_nop), .burst_len(burst_len),
    .trp_cycles(trp_cycles), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .dqm(dqm));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, nlog = 0, dq_tot = 0, bad_dqm = 0, bad_wr = 0, n_wr = 0, acc_t = 0;
  int log_t [64], log_dq [64];
  logic [1:0] log_op [64], log_bk [64];
  logic [7:0] log_col [64];
  logic log_ap [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dqm) dq_tot++;
      if (dqm && cmd != 2'd0) bad_dqm++;
      if (cmd == 2'd2) n_wr++;
      if (cmd == 2'd2 && dqm) bad_wr++;
      if (cmd != 2'd0 && nlog < 64) begin
        log_t[nlog] = cyc; log_dq[nlog] = dq_tot; log_op[nlog] = cmd;
        log_bk[nlog] = cmd_bank; log_col[nlog] = cmd_col; log_ap[nlog] = cmd_ap;
        nlog++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] b, input logic [7:0] c,
                      input logic [3:0] l, input logic ap);
    @(negedge clk);
    req_valid = 1; req_op = op; req_bank = b; req_col = c; req_len = l; req_ap = ap;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc_t = cyc;
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(cmd == 2'd0, "R1 cmd in reset", cmd, 0);
    chk(dqm == 1'b0, "R1 dqm in reset", dqm, 0);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      cas3 = v.cl3; turn_nop = v.tn;
      n0 = nlog;
      send(v.op1, v.b1, 8'h10, v.len, 1'b0);
      send(v.op2, v.b2, 8'h20, v.len, 1'b0);
      repeat (30) @(negedge clk);
      chk(nlog == n0 + 2, $sformatf("R%0d vector %0d command count", v.rid, i), nlog - n0, 2);
      if (nlog == n0 + 2) begin
        chk(log_op[n0] == v.op1 && log_op[n0+1] == v.op2, $sformatf("R%0d vector %0d order", v.rid, i),
            {log_op[n0], log_op[n0+1]}, {v.op1, v.op2});
        chk(log_t[n0+1] - log_t[n0] == int'(v.gap), $sformatf("R%0d vector %0d gap", v.rid, i),
            log_t[n0+1] - log_t[n0], v.gap);
        chk(log_dq[n0+1] - log_dq[n0] == int'(v.dq), $sformatf("R%0d vector %0d dqm cycles", v.rid, i),
            log_dq[n0+1] - log_dq[n0], v.dq);
      end
    end

    // R2: field placement and timing of one read
    cas3 = 0; turn_nop = 0;
    n0 = nlog;
    send(2'd1, 2'd2, 8'hA5, 4'd4, 1'b0);
    repeat (10) @(negedge clk);
    chk(nlog == n0 + 1 && log_t[n0] == acc_t, "R2 read timing", log_t[n0] - acc_t, 0);
    chk(log_bk[n0] == 2'd2 && log_col[n0] == 8'hA5 && log_ap[n0] == 1'b0, "R2 read fields",
        {log_bk[n0], log_col[n0]}, {2'd2, 8'hA5});

    // R2: opcode 0 is taken and yields nothing
    n0 = nlog;
    send(2'd0, 2'd1, 8'h33, 4'd4, 1'b0);
    repeat (10) @(negedge clk);
    chk(nlog == n0, "R2 null opcode dropped", nlog - n0, 0);

    // R10: precharge after an auto-precharged read is dropped
    n0 = nlog;
    send(2'd1, 2'd1, 8'h44, 4'd4, 1'b1);
    send(2'd3, 2'd1, 8'h00, 4'd4, 1'b0);
    repeat (20) @(negedge clk);
    chk(nlog == n0 + 1, "R10 command count", nlog - n0, 1);
    chk(log_op[n0] == 2'd1 && log_ap[n0] == 1'b1, "R10 read carries auto-precharge", log_ap[n0], 1);

    chk(n_wr > 0 && bad_wr == 0, "R5 dqm low on writes", bad_wr, 0);
    chk(bad_dqm == 0, "R12 dqm only on NOP", bad_dqm, 0);
    finish_run();
  end
endmodule